// File: doc/BRIEF.md
# I2C Display Memory Slave Port

This block is the serial front end of a small display memory in a segment LCD driver. It listens on a two-wire I2C bus and answers to one fixed 7-bit device address. A write transaction carries a command byte and then a register address byte. The command byte is held on an output for the rest of the chip. The register address byte sets an internal address pointer. Any further bytes in the same write are stored into the display memory at that pointer, and the pointer advances after each one.

A read begins with a write that sets the pointer. The master then sends a repeated START and the device address with the read bit set. The block returns memory bytes one after another, MSB first. The pointer moves on by one only when the master acknowledges a byte. When the master does not acknowledge, the block releases the data line and stays silent until the next START.

The pointer wraps to zero after its last legal location. A duty-mode input selects that location: 09h for the shorter drive mode and 0Fh for the longer one. Both bus lines are sampled on the system clock. START and STOP are recognised from the sampled lines, and the block only ever pulls SDA low.

Top module: `dram_i2c_slave`

## Requirements
- R1: The block acknowledges address byte 0x70 (write) and 0x71 (read), that is device address 0111000 followed by the R/W bit. It acknowledges by pulling SDA low during the ninth clock. Any other address byte gets no acknowledge, and the block then leaves SDA released until the next START or STOP.
- R2: In a write transaction, the byte after the address byte is acknowledged and appears on `cmd_q` once its eighth bit has been received.
- R3: The third byte of a write transaction is acknowledged and loaded into the pointer. A value above the active last location loads 00h instead.
- R4: Bytes after the register address byte in a write are acknowledged and stored at the pointer. The pointer then advances with the same wrap rule as reads.
- R5: After a repeated START and 0x71, the block sends the byte at the pointer MSB first. SDA changes only while SCL is low.
- R6: The pointer advances by exactly one only when the master acknowledges a sent byte. A byte the master does not acknowledge leaves the pointer on that byte, so the next read starts with the same byte again.
- R7: With `duty_mode` = 0 the pointer wraps from 09h to 00h. With `duty_mode` = 1 it wraps from 0Fh to 00h.
- R8: After the master does not acknowledge a byte, the block keeps SDA released through any further clocks until the next START.
- R9: After a STOP, bits clocked without a new START get no acknowledge, do not drive SDA and do not change the pointer.
- R10: Synchronous active-low reset releases SDA, clears `cmd_q`, sets the pointer to 00h and clears the memory to 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; must be much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| duty_mode | input | 1 | 0: last location 09h, 1: last location 0Fh |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| cmd_q | output | 8 | Last command byte received |

## Verification
The bench aims at the pointer edges: wrap at 09h and at 0Fh in both writes and reads, and register addresses just above the active limit. A design that wrapped at the wrong point, or loaded an out-of-range address as given, would return a byte from the wrong location. It also reads a byte that the master does not acknowledge and then starts a fresh read. A design that advanced on every ninth clock would return the following byte instead of repeating the same one. Foreign addresses, clocks sent after a refused byte and clocks sent after STOP are watched at SDA. Any acknowledge or any driven bit there shows a slave that failed to go quiet. Randomised write/read pairs cover many mixes of start address, length and duty mode.

// File: rtl/drs_pkg.sv
// Package: shared types for the display memory I2C slave.
// Assumes a byte-wide bus protocol and at most 256 memory locations.
package drs_pkg;
    localparam int BYTE_W = 8;

    // Bus-level state of the slave.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_RX_ACK,
        ST_TX,
        ST_TX_ACK
    } bus_state_t;

    // Meaning of the byte being received in the current transaction.
    typedef enum logic [1:0] {
        BK_ADDR,
        BK_CMD,
        BK_REG,
        BK_DATA
    } byte_kind_t;
endpackage

// File: rtl/drs_line_sync.sv
// Module: brings SCL and SDA into the clock domain and finds START/STOP.
// Assumes the system clock samples each SCL phase several times.
// Both lines reset to 1, which is the idle bus level.
module drs_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic scl_d,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              sda_d;

    // Synchronizer chains and one-cycle history of both lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_d    <= 1'b1;
            sda_d    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
            scl_d    <= scl_s;
            sda_d    <= sda_s;
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // An SDA edge while SCL stays high marks START (falling) or STOP (rising).
    always_comb begin
        start_det = scl_s && scl_d && sda_d && !sda_s;
        stop_det  = scl_s && scl_d && !sda_d && sda_s;
    end
endmodule

// File: rtl/drs_ptr.sv
// Module: display memory address pointer with duty-dependent wrap.
// A load above the active last location gives zero; a step from the
// last location (or beyond) gives zero. Assumes AW <= 8.
module drs_ptr #(
    parameter int AW         = 4,
    parameter int SHORT_LAST = 9,
    parameter int LONG_LAST  = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          duty_mode,
    input  logic          load_en,
    input  logic [7:0]    load_val,
    input  logic          step_en,
    output logic [AW-1:0] ptr
);
    localparam logic [7:0]    SHORT_W = 8'(SHORT_LAST);
    localparam logic [7:0]    LONG_W  = 8'(LONG_LAST);
    localparam logic [AW-1:0] ONE     = {{(AW-1){1'b0}}, 1'b1};

    logic [7:0] last_w;
    logic [7:0] ptr_w;

    // Active last location and the pointer widened for comparison.
    always_comb begin
        last_w = duty_mode ? LONG_W : SHORT_W;
        ptr_w  = {{(8-AW){1'b0}}, ptr};
    end

    // Pointer update: load has priority over step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load_en) begin
            ptr <= (load_val > last_w) ? '0 : load_val[AW-1:0];
        end else if (step_en) begin
            ptr <= (ptr_w >= last_w) ? '0 : ptr + ONE;
        end
    end
endmodule

// File: rtl/drs_ram.sv
// Module: small display memory, one register per word, reset to zero.
// One write port and one asynchronous read port.
module drs_ram #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Word g: cleared by reset, written when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mem[g] <= '0;
            end else if (we && (waddr == AW'(g))) begin
                mem[g] <= wdata;
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/dram_i2c_slave.sv
// Module: I2C slave port for the display memory.
// Receives address, command, register address and write data bytes.
// Sends memory bytes MSB first on reads. Only ever pulls SDA low.
// Assumes clk runs at least ~10x the SCL rate and no clock stretching.
module dram_i2c_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h38,
    parameter int         DEPTH       = 16,
    parameter int         SHORT_LAST  = 9,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       duty_mode,
    output logic       sda_pull,
    output logic [7:0] cmd_q
);
    import drs_pkg::*;

    localparam int AW        = $clog2(DEPTH);
    localparam int LONG_LAST = DEPTH - 1;

    logic scl_s, scl_d, sda_s, start_det, stop_det;
    logic scl_rise, scl_fall;

    bus_state_t        state;
    byte_kind_t        kind;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] rx_sr;
    logic [BYTE_W-1:0] tx_sr;
    logic              ack_en;
    logic              is_read;
    logic              master_ack;

    logic              byte_done;
    logic              ptr_load;
    logic              ptr_step;
    logic              ram_we;
    logic [AW-1:0]     ptr;
    logic [BYTE_W-1:0] rd_data;

    drs_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .scl_d     (scl_d),
        .sda_s     (sda_s),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    drs_ptr #(.AW(AW), .SHORT_LAST(SHORT_LAST), .LONG_LAST(LONG_LAST)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .duty_mode (duty_mode),
        .load_en   (ptr_load),
        .load_val  (rx_sr),
        .step_en   (ptr_step),
        .ptr       (ptr)
    );

    drs_ram #(.DEPTH(DEPTH), .W(BYTE_W)) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ram_we),
        .waddr (ptr),
        .wdata (rx_sr),
        .raddr (ptr),
        .rdata (rd_data)
    );

    // Clock edges, end-of-byte strobe and pointer/memory controls.
    always_comb begin
        scl_rise  = scl_s && !scl_d;
        scl_fall  = !scl_s && scl_d;
        byte_done = (state == ST_RX) && scl_fall && (bit_cnt == 4'd8)
                    && !start_det && !stop_det;
        ptr_load  = byte_done && (kind == BK_REG);
        ram_we    = byte_done && (kind == BK_DATA);
        ptr_step  = ram_we
                    || ((state == ST_TX_ACK) && scl_rise && !sda_s
                        && !start_det && !stop_det);
    end

    // Bus state machine: receive, acknowledge, transmit, master ACK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            kind       <= BK_ADDR;
            bit_cnt    <= '0;
            rx_sr      <= '0;
            tx_sr      <= '0;
            ack_en     <= 1'b0;
            is_read    <= 1'b0;
            master_ack <= 1'b0;
            cmd_q      <= '0;
        end else if (start_det) begin
            state   <= ST_RX;
            kind    <= BK_ADDR;
            bit_cnt <= '0;
            ack_en  <= 1'b0;
        end else if (stop_det) begin
            state  <= ST_IDLE;
            ack_en <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && (bit_cnt != 4'd8)) begin
                        rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (byte_done) begin
                        state <= ST_RX_ACK;
                        if (kind == BK_ADDR) begin
                            ack_en  <= (rx_sr[7:1] == DEV_ADDR);
                            is_read <= rx_sr[0];
                        end else begin
                            ack_en <= 1'b1;
                        end
                        if (kind == BK_CMD) begin
                            cmd_q <= rx_sr;
                        end
                    end
                end
                ST_RX_ACK: begin
                    if (scl_fall) begin
                        ack_en  <= 1'b0;
                        bit_cnt <= '0;
                        if (!ack_en) begin
                            state <= ST_IDLE;
                        end else if ((kind == BK_ADDR) && is_read) begin
                            state <= ST_TX;
                            tx_sr <= rd_data;
                        end else begin
                            state <= ST_RX;
                            case (kind)
                                BK_ADDR: kind <= BK_CMD;
                                BK_CMD:  kind <= BK_REG;
                                default: kind <= BK_DATA;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            state <= ST_TX_ACK;
                        end else begin
                            tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        master_ack <= !sda_s;
                    end else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (master_ack) begin
                            state <= ST_TX;
                            tx_sr <= rd_data;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Open-drain drive: ACK slot when accepted, or a zero data bit.
    assign sda_pull = ((state == ST_RX_ACK) && ack_en)
                      || ((state == ST_TX) && !tx_sr[BYTE_W-1]);
endmodule

// File: rtl/drs_checker.sv
// Module: property checker for dram_i2c_slave, attached by bind.
// Watches the drive timing of SDA and the pointer movement rules.
module drs_checker #(
    parameter int AW         = 4,
    parameter int SHORT_LAST = 9,
    parameter int LONG_LAST  = 15
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_s,
    input logic                sda_pull,
    input logic                duty_mode,
    input logic [AW-1:0]       ptr,
    input logic                ptr_load,
    input logic                ptr_step,
    input drs_pkg::bus_state_t state
);
    import drs_pkg::*;

    localparam logic [7:0] SHORT_W = 8'(SHORT_LAST);
    localparam logic [7:0] LONG_W  = 8'(LONG_LAST);

    logic [7:0] last_w;
    logic [7:0] ptr_w;

    // Active last location and widened pointer for bound checks.
    always_comb begin
        last_w = duty_mode ? LONG_W : SHORT_W;
        ptr_w  = {{(8-AW){1'b0}}, ptr};
    end

    // R10: reset leaves SDA released.
    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !sda_pull);

    // R5: the slave starts pulling SDA only while SCL is low.
    a_r5_pull_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> !scl_s);

    // R5: the slave lets go of SDA only while SCL is low.
    a_r5_release_on_low: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> !scl_s);

    // R8: leaving the master-ACK slot for idle means SDA is released.
    a_r8_quiet_after_nack: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_TX_ACK && state == ST_IDLE) |-> !sda_pull);

    // R6: the pointer moves only after a load or a step request.
    a_r6_ptr_moves_on_request: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr != $past(ptr)) |-> ($past(ptr_load) || $past(ptr_step)));

    // R6: a step that does not wrap adds exactly one.
    a_r6_step_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_step) && !$past(ptr_load) && ptr != '0)
            |-> ptr == AW'($past(ptr) + 1'b1));

    // R7: after a step in a steady duty mode the pointer is within range.
    a_r7_wrap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ptr_step) && $stable(duty_mode)) |-> (ptr_w <= last_w));
endmodule

bind dram_i2c_slave drs_checker #(
    .AW         (AW),
    .SHORT_LAST (SHORT_LAST),
    .LONG_LAST  (LONG_LAST)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_pull  (sda_pull),
    .duty_mode (duty_mode),
    .ptr       (ptr),
    .ptr_load  (ptr_load),
    .ptr_step  (ptr_step),
    .state     (state)
);

// File: tb/sim_dram_i2c_slave.sv
// Bench: bus master model with directed corner cases and seeded random
// write/read pairs, checked against a memory and pointer model.
module sim_dram_i2c_slave;
    localparam int HP = 8;   // clk cycles per SCL half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       duty_mode = 1'b0;
    logic       sda_pull;
    logic [7:0] cmd_q;
    logic       sda_bus;

    int n_chk = 0;
    int n_fail = 0;
    int quiet_hits = 0;
    bit watch_quiet = 1'b0;
    bit done = 1'b0;

    logic [7:0] model [16];
    int         mptr = 0;

    assign sda_bus = m_sda & ~sda_pull;

    always #4 clk = ~clk;   // 125 MHz

    dram_i2c_slave u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .duty_mode (duty_mode),
        .sda_pull  (sda_pull),
        .cmd_q     (cmd_q)
    );

    // Count cycles in which the slave drives SDA while it should be silent.
    always @(negedge clk) begin
        if (watch_quiet && sda_pull) quiet_hits++;
    end

    function automatic int last_loc(input bit duty);
        return duty ? 15 : 9;
    endfunction

    function automatic int step_ptr(input int p, input bit duty);
        return (p >= last_loc(duty)) ? 0 : p + 1;
    endfunction

    function automatic int load_ptr(input int v, input bit duty);
        return (v > last_loc(duty)) ? 0 : v;
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(HP);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b0; tick(HP);
        m_scl = 1'b0;
    endtask

    task automatic bus_stop();
        tick(HP / 2); m_sda = 1'b0; tick(HP / 2);
        m_scl = 1'b1; tick(HP);
        m_sda = 1'b1; tick(HP);
    endtask

    // Send one byte and report whether the slave acknowledged it.
    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tick(HP / 2); m_sda = b[i]; tick(HP / 2);
            m_scl = 1'b1; tick(HP);
            m_scl = 1'b0;
        end
        tick(HP / 2); m_sda = 1'b1; tick(HP / 2);
        m_scl = 1'b1; tick(HP / 2);
        acked = !sda_bus;
        tick(HP / 2);
        m_scl = 1'b0;
    endtask

    // Receive one byte, then ACK or NACK it; flags SDA moving while SCL high.
    task automatic recv_byte(input bit ack, output logic [7:0] b, output bit steady);
        logic s1;
        steady = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            tick(HP / 2); m_sda = 1'b1; tick(HP / 2);
            m_scl = 1'b1; tick(1);
            s1 = sda_bus;
            tick(HP - 2);
            if (sda_bus !== s1) steady = 1'b0;
            b = {b[6:0], s1};
            tick(1);
            m_scl = 1'b0;
        end
        tick(HP / 2); m_sda = ack ? 1'b0 : 1'b1; tick(HP / 2);
        m_scl = 1'b1; tick(HP);
        m_scl = 1'b0;
    endtask

    // Write phase: address, command, register address, then nw data bytes.
    task automatic write_phase(input logic [7:0] cmd, input logic [7:0] reg_b,
                               input int nw, input bit do_stop);
        bit a;
        logic [7:0] d;
        bus_start();
        send_byte(8'h70, a);
        chk(a, "R1 write address ack", int'(a), 1);
        send_byte(cmd, a);
        chk(a, "R2 command ack", int'(a), 1);
        chk(cmd_q == cmd, "R2 command stored", int'(cmd_q), int'(cmd));
        send_byte(reg_b, a);
        chk(a, "R3 register address ack", int'(a), 1);
        mptr = load_ptr(int'(reg_b), duty_mode);
        for (int k = 0; k < nw; k++) begin
            d = 8'($urandom);
            send_byte(d, a);
            chk(a, "R4 data ack", int'(a), 1);
            model[mptr] = d;
            mptr = step_ptr(mptr, duty_mode);
        end
        if (do_stop) bus_stop();
    endtask

    // Read phase: START (repeated or fresh), 0x71, nr bytes, last NACKed.
    task automatic read_phase(input int nr, input string tag);
        bit a;
        bit st;
        logic [7:0] b;
        bus_start();
        send_byte(8'h71, a);
        chk(a, "R1 read address ack", int'(a), 1);
        for (int k = 0; k < nr; k++) begin
            recv_byte(k < nr - 1, b, st);
            chk(b == model[mptr], tag, int'(b), int'(model[mptr]));
            chk(st, "R5 SDA steady while SCL high", int'(st), 1);
            if (k < nr - 1) mptr = step_ptr(mptr, duty_mode);
        end
        bus_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        bit a;
        bit st;
        logic [7:0] b;
        int qh;
        void'($urandom(32'h5EED1234));
        for (int i = 0; i < 16; i++) model[i] = 8'h00;

        tick(5);
        rst_n = 1'b1;
        tick(3);

        // R10: reset state at the ports and a read from location 0.
        chk(sda_pull == 1'b0, "R10 SDA released after reset", int'(sda_pull), 0);
        chk(cmd_q == 8'h00, "R10 command cleared", int'(cmd_q), 0);
        mptr = 0;
        read_phase(1, "R10 memory and pointer cleared");

        // R4/R7: fill all 16 locations in the long mode, wrapping past 0Fh.
        duty_mode = 1'b1;
        write_phase(8'hA5, 8'h00, 17, 1'b1);
        write_phase(8'h3C, 8'h0E, 0, 1'b0);
        read_phase(4, "R7 long-mode read wrap 0F->00");

        // R7: short mode write and read across 09h.
        duty_mode = 1'b0;
        write_phase(8'h11, 8'h08, 4, 1'b1);
        write_phase(8'h12, 8'h08, 0, 1'b0);
        read_phase(5, "R7 short-mode wrap 09->00");

        // R3: register address above the active limit loads 00h.
        write_phase(8'h13, 8'h0A, 0, 1'b0);
        chk(mptr == 0, "R3 model load above limit", mptr, 0);
        read_phase(2, "R3 out-of-range load gives 00h");
        duty_mode = 1'b1;
        write_phase(8'h14, 8'h10, 0, 1'b0);
        read_phase(1, "R3 long-mode load of 10h gives 00h");

        // R6/R8: NACK leaves the pointer, slave silent on further clocks.
        write_phase(8'h15, 8'h03, 0, 1'b0);
        bus_start();
        send_byte(8'h71, a);
        chk(a, "R1 read address ack", int'(a), 1);
        recv_byte(1'b1, b, st);
        chk(b == model[3], "R6 first byte", int'(b), int'(model[3]));
        mptr = 4;
        recv_byte(1'b0, b, st);
        chk(b == model[4], "R6 acked step", int'(b), int'(model[4]));
        qh = quiet_hits;
        watch_quiet = 1'b1;
        recv_byte(1'b0, b, st);
        watch_quiet = 1'b0;
        chk(b == 8'hFF, "R8 released after NACK", int'(b), 8'hFF);
        chk(quiet_hits == qh, "R8 no drive after NACK", quiet_hits - qh, 0);
        bus_stop();
        read_phase(1, "R6 NACKed byte repeats on next read");

        // R1: foreign address and following byte are ignored.
        qh = quiet_hits;
        bus_start();
        watch_quiet = 1'b1;
        send_byte(8'h72, a);
        chk(!a, "R1 no ack for 0x72", int'(a), 0);
        send_byte(8'h00, a);
        chk(!a, "R1 byte after foreign address ignored", int'(a), 0);
        bus_start();
        send_byte(8'hF0, a);
        chk(!a, "R1 no ack for 0xF0", int'(a), 0);
        watch_quiet = 1'b0;
        chk(quiet_hits == qh, "R1 SDA never driven", quiet_hits - qh, 0);
        bus_stop();

        // R9: bytes clocked after STOP without START are ignored.
        qh = quiet_hits;
        watch_quiet = 1'b1;
        m_scl = 1'b0;
        send_byte(8'h70, a);
        chk(!a, "R9 no ack after STOP", int'(a), 0);
        send_byte(8'h05, a);
        chk(!a, "R9 second byte after STOP", int'(a), 0);
        watch_quiet = 1'b0;
        chk(quiet_hits == qh, "R9 SDA never driven", quiet_hits - qh, 0);
        m_scl = 1'b1;
        tick(HP);
        read_phase(1, "R9 pointer unchanged after STOP");

        // Random write/read pairs across both duty modes.
        for (int it = 0; it < 24; it++) begin
            int rg;
            int nw;
            int nr;
            duty_mode = 1'($urandom);
            rg = int'($urandom % 20);
            nw = int'($urandom % 10);
            nr = 1 + int'($urandom % 10);
            write_phase(8'($urandom), 8'(rg), nw, 1'b1);
            write_phase(8'($urandom), 8'(rg), 0, 1'b0);
            read_phase(nr, "R5 random sequential read");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule